// File: doc/BRIEF.md
# FPGA Configuration Sequencer with Image Select

This block runs the configuration of an SRAM-based FPGA from an external parallel flash that holds up to eight configuration images. At the start of every attempt it picks one image index. In normal mode the index comes from a 3-bit board selector. In remote-upgrade mode it comes from a 3-bit selector that the FPGA drives. The index is turned into a flash base address. The block then holds the FPGA's active-low configuration request low, waits for the FPGA's active-low status line to be released, and hands the base address to a separate data streamer through a one-cycle start strobe. After that it watches for completion.

The streamer signals the end of the image with a done strobe. Completion is then judged from the FPGA's done line and, optionally, its init-done line. Three events return the sequencer to image selection for a new attempt:
- an error, meaning status is pulled low during loading;
- a timeout while waiting for completion;
- a done line that falls in user mode, meaning the FPGA asks to be reconfigured.

The flash byte path and the per-mode data clocking belong to the streamer and are outside this block.

Top module: `cfg_seq_top`

## Requirements
- R1: While rst_ni is low, ncfg_o is high, strm_start_o is low and user_o is low.
- R2: The image index is fpga_page_i when remote_i is 1 and board_page_i when remote_i is 0.
- R3: strm_addr_o equals the image index shifted left by PAGE_BITS and zero-extended to ADDR_W bits (27 by default).
- R4: Each attempt drives ncfg_o low for exactly NCFG_CYCLES consecutive clocks. user_o and strm_start_o are low during that time.
- R5: After ncfg_o returns high, strm_start_o stays low as long as nstatus_i is low. It pulses high for exactly one clock in the cycle after the first clock in which nstatus_i is seen high.
- R6: nstatus_i low after the start strobe, either while the streamer runs or while completion is awaited, starts a new attempt: ncfg_o goes low again.
- R7: After strm_done_i, user_o rises in the cycle after conf_done_i is high together with init_done_i (init_done_i is ignored when USE_INIT_DONE is 0).
- R8: If completion is not seen within DONE_TIMEOUT clocks after the cycle that samples strm_done_i, a new attempt begins. ncfg_o first reads low DONE_TIMEOUT+1 clocks after that sampling edge.
- R9: In user mode, conf_done_i low drops user_o on the next clock and starts a new attempt.
- R10: The selectors and remote_i are sampled once per attempt, in the cycle before ncfg_o goes low. strm_addr_o changes only at that point, even if the selector inputs change during the attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| remote_i | input | 1 | 1 selects the FPGA-driven image selector |
| board_page_i | input | 3 | Board-level image selector |
| fpga_page_i | input | 3 | FPGA-driven image selector |
| nstatus_i | input | 1 | FPGA status, low means busy or error |
| conf_done_i | input | 1 | FPGA configuration done |
| init_done_i | input | 1 | FPGA initialisation done |
| strm_done_i | input | 1 | Streamer finished sending the image |
| ncfg_o | output | 1 | Configuration request to FPGA, active low |
| strm_start_o | output | 1 | One-cycle start strobe to the streamer |
| strm_addr_o | output | ADDR_W | Flash base address of the chosen image |
| user_o | output | 1 | Configuration complete, FPGA in user mode |

## Verification
The assertions check the following on every cycle:
- the exact width of the configuration request pulse;
- that the start strobe lasts one cycle and comes only after status was high;
- that the base address moves only while the request is low;
- the entry to and exit from user mode, judged from the done line.

The bench scenarios are needed to show the rest:
- the image-source choice and the address arithmetic for every index in both modes;
- the restart on a status error during streaming and during the completion wait;
- the exact timeout distance, including the case of a high done line with a low init-done line;
- that selector changes made mid-attempt do not disturb the running attempt.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int unsigned PAGE_W = 3;

  typedef enum logic [2:0] {
    ST_SEL,
    ST_NCFG,
    ST_WAIT,
    ST_START,
    ST_LOAD,
    ST_CHECK,
    ST_USER
  } seq_st_e;
endpackage

// File: rtl/cfg_page_pick.sv
module cfg_page_pick
  import cfg_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 27,
  parameter int unsigned PAGE_BITS = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic              remote_i,
  input  logic [PAGE_W-1:0] board_page_i,
  input  logic [PAGE_W-1:0] fpga_page_i,
  output logic [ADDR_W-1:0] base_addr_o
);
  localparam int unsigned PAD_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;
  logic [ADDR_W-1:0] page_ext;

  assign page_d = remote_i ? fpga_page_i : board_page_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= '0;
    else if (latch_i) page_q <= page_d;
  end

  assign page_ext    = {{PAD_W{1'b0}}, page_q};
  assign base_addr_o = page_ext << PAGE_BITS;
endmodule

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int unsigned LIM_A = 16,
  parameter int unsigned LIM_B = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic hit_a_o,
  output logic hit_b_o
);
  localparam int unsigned MAX_L = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int unsigned CW    = $clog2(MAX_L + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (cnt_q < CW'(MAX_L))  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_a_o = (cnt_q == CW'(LIM_A - 1));
  assign hit_b_o = (cnt_q == CW'(LIM_B - 1));
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    nstatus_i,
  input  logic    conf_done_i,
  input  logic    init_ok_i,
  input  logic    strm_done_i,
  input  logic    ncfg_hit_i,
  input  logic    tmo_hit_i,
  output seq_st_e st_o,
  output logic    timer_clr_o,
  output logic    latch_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SEL:   st_d = ST_NCFG;
      ST_NCFG:  if (ncfg_hit_i) st_d = ST_WAIT;
      ST_WAIT:  if (nstatus_i) st_d = ST_START;
      ST_START: st_d = ST_LOAD;
      ST_LOAD: begin
        if (!nstatus_i)       st_d = ST_SEL;
        else if (strm_done_i) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (!nstatus_i)                    st_d = ST_SEL;
        else if (conf_done_i && init_ok_i) st_d = ST_USER;
        else if (tmo_hit_i)                st_d = ST_SEL;
      end
      ST_USER:  if (!conf_done_i) st_d = ST_SEL;
      default:  st_d = ST_SEL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SEL;
    else         st_q <= st_d;
  end

  assign st_o        = st_q;
  assign timer_clr_o = (st_d != st_q);
  assign latch_o     = (st_q == ST_SEL);
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 27,
  parameter int unsigned PAGE_BITS     = 24,
  parameter int unsigned NCFG_CYCLES   = 16,
  parameter int unsigned DONE_TIMEOUT  = 4096,
  parameter bit          USE_INIT_DONE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remote_i,
  input  logic [2:0]        board_page_i,
  input  logic [2:0]        fpga_page_i,
  input  logic              nstatus_i,
  input  logic              conf_done_i,
  input  logic              init_done_i,
  input  logic              strm_done_i,
  output logic              ncfg_o,
  output logic              strm_start_o,
  output logic [ADDR_W-1:0] strm_addr_o,
  output logic              user_o
);
  seq_st_e st;
  logic    timer_clr, latch, ncfg_hit, tmo_hit, init_ok;

  generate
    if (USE_INIT_DONE) begin : g_init
      assign init_ok = init_done_i;
    end else begin : g_noinit
      assign init_ok = 1'b1;
    end
  endgenerate

  cfg_page_pick #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) i_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch),
    .remote_i    (remote_i),
    .board_page_i(board_page_i),
    .fpga_page_i (fpga_page_i),
    .base_addr_o (strm_addr_o)
  );

  cfg_cycle_timer #(
    .LIM_A(NCFG_CYCLES),
    .LIM_B(DONE_TIMEOUT)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .hit_a_o(ncfg_hit),
    .hit_b_o(tmo_hit)
  );

  cfg_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nstatus_i  (nstatus_i),
    .conf_done_i(conf_done_i),
    .init_ok_i  (init_ok),
    .strm_done_i(strm_done_i),
    .ncfg_hit_i (ncfg_hit),
    .tmo_hit_i  (tmo_hit),
    .st_o       (st),
    .timer_clr_o(timer_clr),
    .latch_o    (latch)
  );

  assign ncfg_o       = (st != ST_NCFG);
  assign strm_start_o = (st == ST_START);
  assign user_o       = (st == ST_USER);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int unsigned ADDR_W      = 27,
  parameter int unsigned NCFG_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              nstatus_i,
  input logic              conf_done_i,
  input logic              ncfg_o,
  input logic              strm_start_o,
  input logic [ADDR_W-1:0] strm_addr_o,
  input logic              user_o
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= '0;
    else if (ncfg_o) low_cnt <= '0;
    else             low_cnt <= low_cnt + 1;
  end

  // R4
  ncfg_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ncfg_o) |-> (low_cnt == NCFG_CYCLES));

  // R4
  ncfg_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ncfg_o |-> (!user_o && !strm_start_o));

  // R5
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strm_start_o |=> !strm_start_o);

  // R5
  start_after_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strm_start_o |-> $past(nstatus_i));

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strm_addr_o != $past(strm_addr_o)) |-> !ncfg_o);

  // R7
  user_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_o) |-> $past(conf_done_i));

  // R9
  user_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_o && !conf_done_i) |=> !user_o);
endmodule

bind cfg_seq_top cfg_seq_chk #(
  .ADDR_W     (ADDR_W),
  .NCFG_CYCLES(NCFG_CYCLES)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nstatus_i   (nstatus_i),
  .conf_done_i (conf_done_i),
  .ncfg_o      (ncfg_o),
  .strm_start_o(strm_start_o),
  .strm_addr_o (strm_addr_o),
  .user_o      (user_o)
);

// File: tb/test_cfg_seq_top.sv
module test_cfg_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int PB  = 5;
  localparam int NC  = 4;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remote = 1'b0;
  logic [2:0] bpage = '0, fpage = '0;
  logic nstatus = 1'b1, conf_done = 1'b0, init_done = 1'b0, sdone = 1'b0;
  logic ncfg, start, user;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_seq_top #(
    .ADDR_W(AW), .PAGE_BITS(PB), .NCFG_CYCLES(NC),
    .DONE_TIMEOUT(TMO), .USE_INIT_DONE(1'b1)
  ) i_cfg_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .remote_i(remote),
    .board_page_i(bpage), .fpga_page_i(fpage),
    .nstatus_i(nstatus), .conf_done_i(conf_done), .init_done_i(init_done),
    .strm_done_i(sdone), .ncfg_o(ncfg), .strm_start_o(start),
    .strm_addr_o(addr), .user_o(user)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_low(input string req);
    int n = 0;
    while (ncfg && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(!ncfg, req, ncfg, 0);
  endtask

  // one attempt up to the start strobe; exp_pg is the index expected to be latched
  task automatic attempt(input int exp_pg, input string req);
    int low = 0;
    wait_low(req);
    nstatus = 1'b0;
    while (!ncfg && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk(low == NC, "R4 ncfg width", low, NC);
    for (int i = 0; i < 3; i++) begin
      chk(!start, "R5 no start while nstatus low", start, 0);
      @(negedge clk);
    end
    chk(addr == AW'(exp_pg << PB), "R2/R3 base address", addr, exp_pg << PB);
    bpage = ~bpage;
    fpage = ~fpage;
    remote = ~remote;
    nstatus = 1'b1;
    @(negedge clk);
    chk(start, "R5 start pulse", start, 1);
    chk(addr == AW'(exp_pg << PB), "R10 address held", addr, exp_pg << PB);
    @(negedge clk);
    chk(!start, "R5 start one cycle", start, 0);
  endtask

  task automatic finish_ok();
    sdone = 1'b1;
    @(negedge clk);
    sdone = 1'b0;
    conf_done = 1'b1;
    init_done = 1'b1;
    @(negedge clk);
    chk(user, "R7 user mode reached", user, 1);
  endtask

  task automatic drop_done();
    chk(user, "R9 in user before drop", user, 1);
    conf_done = 1'b0;
    init_done = 1'b0;
    @(negedge clk);
    chk(!user, "R9 user falls", user, 0);
  endtask

  task automatic expect_timeout(input string req);
    int k = 0;
    sdone = 1'b1;
    @(negedge clk);
    sdone = 1'b0;
    while (ncfg && k < 100) begin
      chk(!user, req, user, 0);
      @(negedge clk);
      k++;
    end
    chk(k == TMO + 1, req, k, TMO + 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pg;
    repeat (3) @(negedge clk);
    chk(ncfg, "R1 reset ncfg", ncfg, 1);
    chk(!start, "R1 reset start", start, 0);
    chk(!user, "R1 reset user", user, 0);

    // sweep every index in both modes
    for (int i = 0; i < 16; i++) begin
      remote = i[3];
      bpage = 3'(i);
      fpage = 3'(7 - i);
      pg = remote ? (7 - (i % 8)) : (i % 8);
      if (i == 0) rst_n = 1'b1;
      else drop_done();
      attempt(pg, i == 0 ? "R1 start after reset" : "R9 restart after done drop");
      finish_ok();
    end

    // status error during streaming
    remote = 1'b0;
    bpage = 3'd3;
    drop_done();
    attempt(3, "R9 restart");
    nstatus = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!ncfg, "R6 restart on error during load", ncfg, 0);
    chk(!user, "R6 no user", user, 0);
    pg = remote ? int'(fpage) : int'(bpage);
    attempt(pg, "R6 retry");

    // status error during completion wait
    sdone = 1'b1;
    @(negedge clk);
    sdone = 1'b0;
    nstatus = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!ncfg, "R6 restart on error during check", ncfg, 0);
    pg = remote ? int'(fpage) : int'(bpage);
    attempt(pg, "R6 retry");

    // timeout with done low
    expect_timeout("R8 timeout with done low");
    pg = remote ? int'(fpage) : int'(bpage);
    attempt(pg, "R8 retry");

    // done high but init-done low still times out
    conf_done = 1'b1;
    init_done = 1'b0;
    expect_timeout("R7 init_done gates completion");
    conf_done = 1'b0;
    pg = remote ? int'(fpage) : int'(bpage);
    attempt(pg, "R8 retry");
    finish_ok();
    repeat (5) @(negedge clk);
    chk(user, "R7 user stays", user, 1);
    chk(ncfg, "R9 no restart while done high", ncfg, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule